// File: doc/BRIEF.md
# Single-Lane Serial Flash Command Engine

This block drives one arbitrary command onto a serial flash over a single data lane, such as a status read, a configuration write or an erase. The caller presents a command description on its inputs: an 8-bit opcode, a dummy-clock count, and separate enables with byte counts for an address phase, a mode byte, a write-data phase and a read-data phase. The byte counts are coded as the number of bytes minus one. A one-cycle `exec_req` starts the command. `busy` then stays high until the last serial clock of the sequence has finished.

All phases run inside one chip-select assertion and always in the same order: opcode, address, mode byte, dummy clocks, write data, read data. Write bytes come from a 64-bit buffer that is split into a lower and an upper word, and read bytes are stored into two 32-bit result words using the same byte layout. The serial interface runs in clock mode 0. The clock idles low, the engine changes `mosi` at the start of each low half, and it samples `miso` on each rising edge. Each half period of the serial clock is `HALF_PERIOD` system clocks long.

Top module: `flash_cmd_engine`

## Requirements
- R1: Out of reset, and whenever no command runs, `cs_n` is high, `sclk` and `mosi` are low, `busy` is low, and after reset both read words are zero.
- R2: `exec_req` sampled high while `busy` is low starts a command. From the next cycle, `busy` is high and `cs_n` is low for exactly 2·HALF_PERIOD·N cycles, where N is the total bit count of the enabled phases.
- R3: Each serial bit takes one low half followed by one high half of `sclk`, each HALF_PERIOD cycles long. `sclk` is low in the first cycle of a command, and `mosi` changes only when `sclk` goes low or when a command starts.
- R4: The first 8 bits are the opcode, sent most significant bit first.
- R5: When the address enable is set, addr_cnt+1 bytes follow the opcode. They are the low 8·(addr_cnt+1) bits of `address`, sent most significant bit first.
- R6: When the mode enable is set, the 8 bits of `mode_bits` follow the address phase, most significant bit first.
- R7: `dummy_cycles` (0 to 31) serial clocks with `mosi` low follow the mode phase.
- R8: When the write enable is set, wr_cnt+1 bytes follow the dummy clocks. Byte k is bits [8k+7:8k] of {wdata_hi, wdata_lo}, byte 0 goes first, and each byte is sent most significant bit first.
- R9: When the read enable is set, rd_cnt+1 bytes are received last while `mosi` stays low. The first bit of received byte k lands in bit 8k+7 of {rdata_hi, rdata_lo}. Levels on `miso` outside the read phase are never stored.
- R10: A command with a read phase clears all 64 read bits when it starts, so byte positions beyond the count read as zero. A command without a read phase leaves the read words unchanged.
- R11: `exec_req` while `busy` is high is ignored. The running sequence and its length are unaffected.
- R12: The command inputs are captured when a command starts. Changes to them while `busy` is high do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_req | input | 1 | Start request, acted on only while idle |
| opcode | input | 8 | Command opcode |
| dummy_cycles | input | 5 | Number of dummy serial clocks |
| addr_en | input | 1 | Address phase enable |
| addr_cnt | input | 2 | Address bytes minus one |
| mode_en | input | 1 | Mode byte phase enable |
| mode_bits | input | 8 | Mode byte value |
| wr_en | input | 1 | Write data phase enable |
| wr_cnt | input | 3 | Write bytes minus one |
| rd_en | input | 1 | Read data phase enable |
| rd_cnt | input | 3 | Read bytes minus one |
| address | input | 32 | Address value |
| wdata_lo | input | 32 | Write bytes 0 to 3 |
| wdata_hi | input | 32 | Write bytes 4 to 7 |
| miso | input | 1 | Serial data from flash |
| busy | output | 1 | Command in progress |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| rdata_lo | output | 32 | Read bytes 0 to 3 |
| rdata_hi | output | 32 | Read bytes 4 to 7 |

## Verification
An error in the phase or bit counter appears on `mosi` during the first serial bit that comes from the wrong source. Because the model predicts `mosi` in every system cycle, the mismatch is reported within one half period of the faulty step. A wrong phase length or a skipped phase shifts the point where `cs_n` rises, and this shows up in `busy` and `cs_n` on the cycle where the expected and actual ends differ. A wrong read byte or bit position, or a missing clear, only shows in `rdata_lo` and `rdata_hi`. These words are compared on every idle cycle, starting with the cycle right after the command ends.

// File: rtl/fce_pkg.sv
package fce_pkg;

  localparam int OPC_BITS    = 8;
  localparam int ADDR_BYTES  = 4;
  localparam int DATA_BYTES  = 8;
  localparam int DUMMY_W     = 5;
  localparam int ADDR_W      = 8 * ADDR_BYTES;
  localparam int DATA_W      = 8 * DATA_BYTES;
  localparam int ACNT_W      = $clog2(ADDR_BYTES);
  localparam int DCNT_W      = $clog2(DATA_BYTES);
  localparam int BIT_IDX_W   = $clog2(DATA_W);
  localparam int BITCNT_W    = BIT_IDX_W + 1;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_MODE  = 3'd3,
    PH_DUMMY = 3'd4,
    PH_WR    = 3'd5,
    PH_RD    = 3'd6
  } fce_phase_e;

  typedef struct packed {
    logic [OPC_BITS-1:0] opcode;
    logic [DUMMY_W-1:0]  dummy;
    logic                addr_en;
    logic [ACNT_W-1:0]   addr_cnt;
    logic                mode_en;
    logic [7:0]          mode_bits;
    logic                wr_en;
    logic [DCNT_W-1:0]   wr_cnt;
    logic                rd_en;
    logic [DCNT_W-1:0]   rd_cnt;
    logic [ADDR_W-1:0]   address;
    logic [DATA_W-1:0]   wdata;
  } fce_cfg_t;

  // Whether a given phase takes part in the command
  function automatic logic phase_on(fce_phase_e ph, fce_cfg_t c);
    logic on;
    case (ph)
      PH_OPC:   on = 1'b1;
      PH_ADDR:  on = c.addr_en;
      PH_MODE:  on = c.mode_en;
      PH_DUMMY: on = (c.dummy != '0);
      PH_WR:    on = c.wr_en;
      PH_RD:    on = c.rd_en;
      default:  on = 1'b0;
    endcase
    return on;
  endfunction

  // First enabled phase after ph in fixed order; PH_IDLE when none is left
  function automatic fce_phase_e next_phase(fce_phase_e ph, fce_cfg_t c);
    fce_phase_e nxt;
    logic       found;
    nxt   = PH_IDLE;
    found = 1'b0;
    for (int p = 1; p <= 6; p++) begin
      if (!found && (p > int'(ph)) && phase_on(fce_phase_e'(p), c)) begin
        nxt   = fce_phase_e'(p);
        found = 1'b1;
      end
    end
    return nxt;
  endfunction

  // Number of serial bits in a phase
  function automatic logic [BITCNT_W-1:0] phase_len(fce_phase_e ph, fce_cfg_t c);
    logic [BITCNT_W-1:0] len;
    case (ph)
      PH_OPC:   len = BITCNT_W'(OPC_BITS);
      PH_ADDR:  len = BITCNT_W'({c.addr_cnt, 3'b000}) + BITCNT_W'(8);
      PH_MODE:  len = BITCNT_W'(8);
      PH_DUMMY: len = BITCNT_W'(c.dummy);
      PH_WR:    len = BITCNT_W'({c.wr_cnt, 3'b000}) + BITCNT_W'(8);
      PH_RD:    len = BITCNT_W'({c.rd_cnt, 3'b000}) + BITCNT_W'(8);
      default:  len = '0;
    endcase
    return len;
  endfunction

  // Position inside a 64-bit buffer of serial bit b: byte b/8, MSB first
  function automatic logic [BIT_IDX_W-1:0] data_pos(logic [BITCNT_W-1:0] b);
    return {b[BIT_IDX_W-1:3], ~b[2:0]};
  endfunction

endpackage

// File: rtl/fce_sclk_gen.sv
module fce_sclk_gen #(
  parameter int HALF_PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hi_q, hi_d;
  logic             half_end;

  assign half_end  = run && !start && (cnt_q == CNT_LAST);
  assign rise_tick = half_end && !hi_q;
  assign fall_tick = half_end && hi_q;
  assign sclk      = hi_q;

  always_comb begin
    cnt_d = cnt_q;
    hi_d  = hi_q;
    if (start || !run) begin
      cnt_d = '0;
      hi_d  = 1'b0;
    end else if (half_end) begin
      cnt_d = '0;
      hi_d  = !hi_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

endmodule

// File: rtl/fce_sequencer.sv
module fce_sequencer
  import fce_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  fce_cfg_t            cfg,
  input  logic                fall_tick,
  output fce_phase_e          phase,
  output logic [BITCNT_W-1:0] bit_cnt,
  output logic                busy,
  output logic                cs_n,
  output logic                mosi
);

  fce_phase_e          phase_q, phase_d, phase_nx;
  logic [BITCNT_W-1:0] bit_q, bit_d, len;
  logic                cs_q, cs_d;
  logic                last_bit;
  logic [4:0]          addr_pos;
  logic [BIT_IDX_W-1:0] wr_pos;

  assign len      = phase_len(phase_q, cfg);
  assign last_bit = (bit_q == len - BITCNT_W'(1));
  assign phase_nx = next_phase(phase_q, cfg);

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    cs_d    = cs_q;
    if (start) begin
      phase_d = PH_OPC;
      bit_d   = '0;
      cs_d    = 1'b0;
    end else if ((phase_q != PH_IDLE) && fall_tick) begin
      if (last_bit) begin
        phase_d = phase_nx;
        bit_d   = '0;
        if (phase_nx == PH_IDLE) cs_d = 1'b1;
      end else begin
        bit_d = bit_q + BITCNT_W'(1);
      end
    end
  end

  // Transmit bit selection from the captured command
  assign addr_pos = {cfg.addr_cnt, 3'b111} - bit_q[4:0];
  assign wr_pos   = data_pos(bit_q);

  always_comb begin
    case (phase_q)
      PH_OPC:  mosi = cfg.opcode[~bit_q[2:0]];
      PH_ADDR: mosi = cfg.address[addr_pos];
      PH_MODE: mosi = cfg.mode_bits[~bit_q[2:0]];
      PH_WR:   mosi = cfg.wdata[wr_pos];
      default: mosi = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      cs_q    <= 1'b1;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      cs_q    <= cs_d;
    end
  end

  assign phase   = phase_q;
  assign bit_cnt = bit_q;
  assign busy    = (phase_q != PH_IDLE);
  assign cs_n    = cs_q;

endmodule

// File: rtl/fce_rx_capture.sv
module fce_rx_capture
  import fce_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                sample,
  input  logic [BITCNT_W-1:0] bit_cnt,
  input  logic                miso,
  output logic [DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0]    rd_q, rd_d;
  logic [BIT_IDX_W-1:0] pos;

  assign pos = data_pos(bit_cnt);

  always_comb begin
    rd_d = rd_q;
    if (clear) begin
      rd_d = '0;
    end else if (sample) begin
      rd_d[pos] = miso;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (clear || sample) begin
      rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int HALF_PERIOD = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exec_req,
  input  logic [OPC_BITS-1:0] opcode,
  input  logic [DUMMY_W-1:0]  dummy_cycles,
  input  logic                addr_en,
  input  logic [ACNT_W-1:0]   addr_cnt,
  input  logic                mode_en,
  input  logic [7:0]          mode_bits,
  input  logic                wr_en,
  input  logic [DCNT_W-1:0]   wr_cnt,
  input  logic                rd_en,
  input  logic [DCNT_W-1:0]   rd_cnt,
  input  logic [ADDR_W-1:0]   address,
  input  logic [31:0]         wdata_lo,
  input  logic [31:0]         wdata_hi,
  input  logic                miso,
  output logic                busy,
  output logic                cs_n,
  output logic                sclk,
  output logic                mosi,
  output logic [31:0]         rdata_lo,
  output logic [31:0]         rdata_hi
);

  // Reset: asserted asynchronously, released after SYNC_STAGES clocks
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  fce_cfg_t            cfg_in, cfg_q;
  logic                start;
  logic                rise_tick, fall_tick;
  fce_phase_e          phase;
  logic [BITCNT_W-1:0] bit_cnt;
  logic [DATA_W-1:0]   rdata;

  assign cfg_in = '{opcode:    opcode,
                    dummy:     dummy_cycles,
                    addr_en:   addr_en,
                    addr_cnt:  addr_cnt,
                    mode_en:   mode_en,
                    mode_bits: mode_bits,
                    wr_en:     wr_en,
                    wr_cnt:    wr_cnt,
                    rd_en:     rd_en,
                    rd_cnt:    rd_cnt,
                    address:   address,
                    wdata:     {wdata_hi, wdata_lo}};

  assign start = exec_req && !busy;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= '0;
    else if (start)  cfg_q <= cfg_in;
  end

  fce_sclk_gen #(.HALF_PERIOD(HALF_PERIOD)) u_sclk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .run       (busy),
    .sclk      (sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  fce_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .cfg       (cfg_q),
    .fall_tick (fall_tick),
    .phase     (phase),
    .bit_cnt   (bit_cnt),
    .busy      (busy),
    .cs_n      (cs_n),
    .mosi      (mosi)
  );

  fce_rx_capture u_rx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear   (start && rd_en),
    .sample  (rise_tick && (phase == PH_RD)),
    .bit_cnt (bit_cnt),
    .miso    (miso),
    .rdata   (rdata)
  );

  assign rdata_lo = rdata[31:0];
  assign rdata_hi = rdata[DATA_W-1:32];

endmodule

// File: rtl/fce_checker.sv
module fce_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        exec_req,
  input logic        rd_en,
  input logic        busy,
  input logic        cs_n,
  input logic        sclk,
  input logic        mosi,
  input logic [31:0] rdata_lo,
  input logic [31:0] rdata_hi
);

  a_r2_select_matches_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);

  a_r1_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !mosi));

  a_r3_first_cycle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_req && !busy) |=> (busy && !sclk));

  a_r3_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sclk) |=> (!sclk || $stable(mosi)));

  a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_req && !busy && rd_en) |=> (rdata_lo == 32'd0 && rdata_hi == 32'd0));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !exec_req) |=> ($stable(rdata_lo) && $stable(rdata_hi)));

endmodule

bind flash_cmd_engine fce_checker i_fce_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .exec_req (exec_req),
  .rd_en    (rd_en),
  .busy     (busy),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .rdata_lo (rdata_lo),
  .rdata_hi (rdata_hi)
);

// File: tb/test_flash_cmd_engine.sv
`timescale 1ns/1ps
module test_flash_cmd_engine;

  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_req = 1'b0;
  logic [7:0]  opcode = '0;
  logic [4:0]  dummy_cycles = '0;
  logic        addr_en = 1'b0;
  logic [1:0]  addr_cnt = '0;
  logic        mode_en = 1'b0;
  logic [7:0]  mode_bits = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_cnt = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_cnt = '0;
  logic [31:0] address = '0;
  logic [31:0] wdata_lo = '0;
  logic [31:0] wdata_hi = '0;
  logic        miso;
  logic        busy, cs_n, sclk, mosi;
  logic [31:0] rdata_lo, rdata_hi;

  always #2.5 clk = ~clk;

  flash_cmd_engine #(.HALF_PERIOD(H)) i_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .exec_req(exec_req), .opcode(opcode),
    .dummy_cycles(dummy_cycles), .addr_en(addr_en), .addr_cnt(addr_cnt),
    .mode_en(mode_en), .mode_bits(mode_bits), .wr_en(wr_en), .wr_cnt(wr_cnt),
    .rd_en(rd_en), .rd_cnt(rd_cnt), .address(address), .wdata_lo(wdata_lo),
    .wdata_hi(wdata_hi), .miso(miso), .busy(busy), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .rdata_lo(rdata_lo), .rdata_hi(rdata_hi));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  bit cmp_on = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        tx_s [256];
  string     tag_s[256];
  bit        rx_s [256];
  int        m_t = 0, m_n = 0, seed = 0;
  bit        m_busy = 0;
  logic [63:0] m_rd = '0;

  task automatic push(bit b, string t, bit r);
    tx_s[m_n] = b; tag_s[m_n] = t; rx_s[m_n] = r; m_n++;
  endtask

  task automatic build();
    logic [63:0] wd;
    logic [7:0]  rb;
    m_n = 0;
    wd = {wdata_hi, wdata_lo};
    for (int i = 7; i >= 0; i--) push(opcode[i], "R4", 1'b1);
    if (addr_en)
      for (int i = (int'(addr_cnt) + 1) * 8 - 1; i >= 0; i--) push(address[i], "R5", 1'b1);
    if (mode_en)
      for (int i = 7; i >= 0; i--) push(mode_bits[i], "R6", 1'b1);
    for (int i = 0; i < int'(dummy_cycles); i++) push(1'b0, "R7", 1'b1);
    if (wr_en)
      for (int k = 0; k <= int'(wr_cnt); k++)
        for (int b = 7; b >= 0; b--) push(wd[8*k+b], "R8", 1'b1);
    if (rd_en) begin
      m_rd = '0;   // R10 clear at start
      seed++;
      for (int k = 0; k <= int'(rd_cnt); k++) begin
        rb = 8'(seed * 29 + k * 71 + 5);
        m_rd[8*k +: 8] = rb;
        for (int b = 7; b >= 0; b--) push(1'b0, "R9", rb[b]);
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0;
      m_t    = 0;
      miso  <= 1'b0;
    end else begin
      if (m_busy) begin
        m_t++;
        if (m_t == m_n * 2 * H) m_busy = 0;
      end else if (exec_req) begin   // R11: ignored while busy
        build();                     // R12: inputs captured here
        m_busy = 1;
        m_t    = 0;
      end
      miso <= m_busy ? rx_s[m_t / (2*H)] : 1'b1;
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R2", {63'd0, busy}, {63'd0, m_busy});
      chk("R2", {63'd0, cs_n}, {63'd0, !m_busy});
      chk("R3", {63'd0, sclk}, {63'd0, m_busy && ((m_t / H) % 2 == 1)});
      if (m_busy) chk(tag_s[m_t / (2*H)], {63'd0, mosi}, {63'd0, tx_s[m_t / (2*H)]});
      else begin
        chk("R1", {63'd0, mosi}, 64'd0);
        chk("R9", {rdata_hi, rdata_lo}, m_rd);
      end
    end
  end

  task automatic go();
    @(negedge clk); exec_req = 1'b1;
    @(negedge clk); exec_req = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] op, input logic [4:0] dm,
                     input logic ae, input logic [1:0] ac,
                     input logic me, input logic [7:0] mb,
                     input logic we, input logic [2:0] wc,
                     input logic re, input logic [2:0] rc);
    opcode = op; dummy_cycles = dm; addr_en = ae; addr_cnt = ac;
    mode_en = me; mode_bits = mb; wr_en = we; wr_cnt = wc; rd_en = re; rd_cnt = rc;
  endtask

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle state after reset
    chk("R1", {60'd0, busy, cs_n, sclk, mosi}, {60'd0, 4'b0100});
    chk("R1", {rdata_hi, rdata_lo}, 64'd0);
    cmp_on = 1;

    // status read: opcode and one read byte
    cfg(8'h05, 5'd0, 0, 2'd0, 0, 8'h00, 0, 3'd0, 1, 3'd0);
    go();
    // opcode only
    cfg(8'hA6, 5'd0, 0, 2'd0, 0, 8'h00, 0, 3'd0, 0, 3'd0);
    go();
    // 3 address bytes, 8 dummy clocks, 8 read bytes
    address = 32'h5C3A_91E7;
    cfg(8'h0B, 5'd8, 1, 2'd2, 0, 8'h00, 0, 3'd0, 1, 3'd7);
    go();
    // 4 address bytes, mode byte, 8 write bytes
    address = 32'hD2B4_1C69; wdata_lo = 32'h8877_6655; wdata_hi = 32'h1E2D_3C4B;
    cfg(8'h12, 5'd0, 1, 2'd3, 1, 8'hC3, 1, 3'd7, 0, 3'd0);
    go();
    // write 1 byte then read 2: upper positions must be cleared
    wdata_lo = 32'h0000_00B1;
    cfg(8'h71, 5'd0, 0, 2'd0, 0, 8'h00, 1, 3'd0, 1, 3'd1);
    go();
    chk("R10", {32'd0, rdata_hi}, 64'd0);
    chk("R10", {48'd0, rdata_lo[31:16]}, 64'd0);
    // no read phase: read words unchanged
    begin
      logic [63:0] keep;
      keep = {rdata_hi, rdata_lo};
      cfg(8'h06, 5'd3, 1, 2'd0, 1, 8'h5A, 1, 3'd2, 0, 3'd0);
      address = 32'h0000_0042; wdata_lo = 32'h00A1_B2C3;
      go();
      chk("R10", {rdata_hi, rdata_lo}, keep);
    end
    // maximum dummy clocks, 1 address byte, 5 read bytes
    address = 32'h0000_00F0;
    cfg(8'hEB, 5'd31, 1, 2'd0, 0, 8'h00, 0, 3'd0, 1, 3'd4);
    go();
    // R11/R12: re-trigger and change inputs while running
    address = 32'h0013_5790;
    cfg(8'h3B, 5'd2, 1, 2'd1, 1, 8'h81, 1, 3'd1, 1, 3'd2);
    wdata_lo = 32'h0000_F00D;
    @(negedge clk); exec_req = 1'b1;
    @(negedge clk); exec_req = 1'b0;
    repeat (20) @(negedge clk);
    opcode = 8'hFF; address = 32'hFFFF_FFFF; wdata_lo = 32'hFFFF_FFFF;
    addr_en = 0; rd_cnt = 3'd7; mode_bits = 8'h00;
    exec_req = 1'b1;
    @(negedge clk); exec_req = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R11", {63'd0, busy}, 64'd0);
    chk("R12", {rdata_hi, rdata_lo}, m_rd);
    // back-to-back: request held high across the end of a command
    cfg(8'h9F, 5'd0, 0, 2'd0, 0, 8'h00, 0, 3'd0, 1, 3'd2);
    @(negedge clk); exec_req = 1'b1;
    repeat (3) @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk); exec_req = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R2", {63'd0, busy}, 64'd0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule